// File: doc/BRIEF.md
# Threshold FIFO with DMA Requests

This block is the word buffer that sits between a memory-card host controller's bus-visible data port and its card-side transfer engine. It holds 16-bit words in a 32-entry circular store. The direction input selects which side fills the buffer and which side empties it. When data moves from card to host, the card engine pushes and host reads pop. When data moves from host to card, host writes push and the card engine pops.

A 16-bit buffer configuration word sets two 5-bit watermarks and one DMA enable for each direction. When the occupancy rises above the almost-full watermark in card-to-host mode, or falls below the almost-empty watermark in host-to-card mode, the block raises one of two outputs. If that direction's DMA enable is set, it raises the direction's DMA request line. Otherwise it raises a status flag for the controller's status register. Both flags are forced low while the controller is idle and the buffer is empty. Writing the configuration word also empties the buffer.

Top module: `thresh_fifo`

## Requirements
- R1: After reset the buffer is empty, the DMA requests and status flags are low, and the configuration reads 0x1F00 (almost-empty 0, almost-full 31, both DMA enables off).
- R2: Words leave the buffer in the order they entered, including when the circular index wraps past entry 31 back to entry 0.
- R3: A push attempted while 32 words are held is discarded: the occupancy stays 32 and the stored words are unchanged.
- R4: A host read in card-to-host mode with an empty buffer raises `host_underrun` in that cycle and presents the word at the head index on `host_rd_data`. The occupancy stays 0.
- R5: Configuration layout: bit 15 is the receive DMA enable, bits 12:8 the almost-full level, bit 7 the transmit DMA enable and bits 4:0 the almost-empty level. Bits 14:13 and 6:5 read as 0. A configuration write empties the buffer.
- R6: In card-to-host mode with receive DMA enabled, `rx_dma_req` is high exactly when the occupancy exceeds the almost-full level, and `stat_almost_full` stays low.
- R7: In card-to-host mode with receive DMA disabled, `stat_almost_full` is high exactly when the occupancy exceeds the almost-full level, and `rx_dma_req` stays low.
- R8: In host-to-card mode, the condition is occupancy below the almost-empty level. If transmit DMA is enabled the condition drives `tx_dma_req`; otherwise it drives `stat_almost_empty`.
- R9: While `xfer_active` is low and the buffer is empty, both status flags are low whatever the levels are.
- R10: A request or flag falls in the same cycle that the occupancy stops meeting its condition.
- R11: Direction gating: in card-to-host mode host writes and card pops have no effect. In host-to-card mode card pushes and host reads have no effect and never raise `host_underrun`.
- R12: A push and a pop in the same cycle, with the buffer neither full nor empty, leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| card_to_host | input | 1 | 1: card fills and host drains; 0: host fills and card drains |
| xfer_active | input | 1 | A data transfer is in progress |
| cfg_wr_en | input | 1 | Write strobe for the buffer configuration word |
| cfg_wr_data | input | 16 | Configuration value to write |
| cfg_rd_data | output | 16 | Current configuration readback |
| host_wr_en | input | 1 | Host write to the data port |
| host_wr_data | input | 16 | Host write word |
| host_rd_en | input | 1 | Host read of the data port |
| host_rd_data | output | 16 | Word at the head of the buffer |
| host_underrun | output | 1 | Host read attempted on an empty buffer |
| card_push_en | input | 1 | Card engine pushes a word |
| card_push_data | input | 16 | Card engine word |
| card_pop_en | input | 1 | Card engine pops a word |
| card_rd_data | output | 16 | Word at the head of the buffer, for the card engine |
| fill_level | output | 6 | Current occupancy, 0 to 32 |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| stat_almost_full | output | 1 | Almost-full status flag |
| stat_almost_empty | output | 1 | Almost-empty status flag |

## Verification
The bench sweeps every watermark value against every occupancy from 0 to 32 in both directions, with the DMA enable both on and off. A comparison off by one, such as `>=` in place of `>`, or a route sent to the wrong output fails at the exact boundary count. It fills the buffer to 32, attempts an extra push, and drains it in order. A design that overwrites the head or counts to 33 returns a corrupted first word. It also runs a wrap and a simultaneous push-and-pop phase, which catch a write index that ignores the start pointer. It covers an underrun read, an idle empty buffer with a nonzero almost-empty level, and a configuration write into a partly filled buffer. These catch a pop on an empty buffer, a status flag that is not masked while idle, and a missing flush.

// File: rtl/thf_pkg.sv
// Package: shared types for the threshold FIFO.
// Holds the buffer configuration record and the helpers that map it to
// and from the 16-bit configuration word. Field positions are fixed.
package thf_pkg;

    localparam int LVL_W = 5;
    localparam int CFG_W = 16;

    typedef struct packed {
        logic             rx_en;
        logic [LVL_W-1:0] af_lvl;
        logic             tx_en;
        logic [LVL_W-1:0] ae_lvl;
    } buf_cfg_t;

    // Unpack a configuration word: rx enable 15, full level 12:8, tx enable 7, empty level 4:0.
    function automatic buf_cfg_t cfg_unpack(input logic [CFG_W-1:0] w);
        buf_cfg_t c;
        c.rx_en  = w[15];
        c.af_lvl = w[8 +: LVL_W];
        c.tx_en  = w[7];
        c.ae_lvl = w[0 +: LVL_W];
        return c;
    endfunction

    // Pack the record back into a word; unused bits read as zero.
    function automatic logic [CFG_W-1:0] cfg_pack(input buf_cfg_t c);
        logic [CFG_W-1:0] w;
        w              = '0;
        w[15]          = c.rx_en;
        w[8 +: LVL_W]  = c.af_lvl;
        w[7]           = c.tx_en;
        w[0 +: LVL_W]  = c.ae_lvl;
        return w;
    endfunction

endpackage

// File: rtl/thf_store.sv
// Module: thf_store
// Circular word store with occupancy tracking. The write index is the
// start index plus the length, modulo the depth. A push while full and a
// pop while empty are dropped. A flush returns the store to empty and takes
// priority over a push or pop in the same cycle.
// Assumes at most one push and one pop per cycle.
module thf_store #(
    parameter int DW = 16,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head_data,
    output logic [AW:0]   count,
    output logic          full,
    output logic          empty
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] start_idx;
    logic [AW-1:0] wr_idx;
    logic          do_push;
    logic          do_pop;

    // Derive the full and empty flags, the accepted moves and the write index.
    always_comb begin
        full      = (count == (AW+1)'(DEPTH));
        empty     = (count == '0);
        do_push   = push && !full;
        do_pop    = pop && !empty;
        wr_idx    = start_idx + count[AW-1:0];
        head_data = mem[start_idx];
    end

    // Store an accepted word; the storage array is not reset.
    always_ff @(posedge clk) begin
        if (do_push && !flush) begin
            mem[wr_idx] <= push_data;
        end
    end

    // Advance the start index and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            start_idx <= '0;
            count     <= '0;
        end else begin
            if (do_pop) begin
                start_idx <= start_idx + 1'b1;
            end
            count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

endmodule

// File: rtl/thf_cfg.sv
// Module: thf_cfg
// Buffer configuration register. It holds the watermarks and DMA enables
// and gives the readback word. A write raises a flush for the store in
// the same cycle. Reset leaves almost-empty at 0, almost-full at all
// ones and both enables off.
module thf_cfg (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [thf_pkg::CFG_W-1:0] wr_data,
    output thf_pkg::buf_cfg_t         cfg,
    output logic [thf_pkg::CFG_W-1:0] rd_data,
    output logic                      flush
);
    import thf_pkg::*;

    // Load the configuration record on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.rx_en  <= 1'b0;
            cfg.af_lvl <= '1;
            cfg.tx_en  <= 1'b0;
            cfg.ae_lvl <= '0;
        end else if (wr_en) begin
            cfg <= cfg_unpack(wr_data);
        end
    end

    // Readback and flush request.
    always_comb begin
        rd_data = cfg_pack(cfg);
        flush   = wr_en;
    end

endmodule

// File: rtl/thf_thresh.sv
// Module: thf_thresh
// Watermark comparison and routing. Each crossing goes to a DMA request
// when that direction's enable is set, and to a status flag otherwise.
// Status flags are masked while idle with an empty store. Purely
// combinational, so outputs follow the occupancy in the same cycle.
module thf_thresh #(
    parameter int AW = 5
) (
    input  thf_pkg::buf_cfg_t cfg,
    input  logic [AW:0]       count,
    input  logic              card_to_host,
    input  logic              xfer_active,
    output logic              rx_dma_req,
    output logic              tx_dma_req,
    output logic              stat_almost_full,
    output logic              stat_almost_empty
);
    logic over_full;
    logic under_empty;
    logic idle_empty;

    // Compare the occupancy with the watermarks and route the result.
    always_comb begin
        over_full         = card_to_host && (count > (AW+1)'(cfg.af_lvl));
        under_empty       = !card_to_host && (count < (AW+1)'(cfg.ae_lvl));
        idle_empty        = !xfer_active && (count == '0);
        rx_dma_req        = over_full && cfg.rx_en;
        tx_dma_req        = under_empty && cfg.tx_en;
        stat_almost_full  = over_full && !cfg.rx_en && !idle_empty;
        stat_almost_empty = under_empty && !cfg.tx_en && !idle_empty;
    end

endmodule

// File: rtl/thresh_fifo.sv
// Module: thresh_fifo (top)
// Data buffer between the host data port and the card transfer engine.
// The direction input chooses which side pushes and which side pops;
// requests from the other side are ignored. Watermark outputs come from
// thf_thresh and occupancy from thf_store.
// Assumes DW is 16 and AW equals thf_pkg::LVL_W.
module thresh_fifo #(
    parameter int DW = 16,
    parameter int AW = thf_pkg::LVL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          card_to_host,
    input  logic          xfer_active,
    input  logic          cfg_wr_en,
    input  logic [15:0]   cfg_wr_data,
    output logic [15:0]   cfg_rd_data,
    input  logic          host_wr_en,
    input  logic [DW-1:0] host_wr_data,
    input  logic          host_rd_en,
    output logic [DW-1:0] host_rd_data,
    output logic          host_underrun,
    input  logic          card_push_en,
    input  logic [DW-1:0] card_push_data,
    input  logic          card_pop_en,
    output logic [DW-1:0] card_rd_data,
    output logic [AW:0]   fill_level,
    output logic          rx_dma_req,
    output logic          tx_dma_req,
    output logic          stat_almost_full,
    output logic          stat_almost_empty
);
    thf_pkg::buf_cfg_t cfg;
    logic              flush;
    logic              push;
    logic              pop;
    logic [DW-1:0]     push_data;
    logic [DW-1:0]     head;
    logic              full;
    logic              empty;

    // Select the push and pop sources by direction.
    always_comb begin
        push          = card_to_host ? card_push_en : host_wr_en;
        push_data     = card_to_host ? card_push_data : host_wr_data;
        pop           = card_to_host ? host_rd_en : card_pop_en;
        host_underrun = card_to_host && host_rd_en && empty;
        host_rd_data  = head;
        card_rd_data  = head;
    end

    thf_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .cfg     (cfg),
        .rd_data (cfg_rd_data),
        .flush   (flush)
    );

    thf_store #(.DW(DW), .AW(AW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .head_data (head),
        .count     (fill_level),
        .full      (full),
        .empty     (empty)
    );

    thf_thresh #(.AW(AW)) u_thresh (
        .cfg               (cfg),
        .count             (fill_level),
        .card_to_host      (card_to_host),
        .xfer_active       (xfer_active),
        .rx_dma_req        (rx_dma_req),
        .tx_dma_req        (tx_dma_req),
        .stat_almost_full  (stat_almost_full),
        .stat_almost_empty (stat_almost_empty)
    );

endmodule

// File: rtl/thresh_fifo_chk.sv
// Module: thresh_fifo_chk
// Property checker bound to thresh_fifo. It sees only the top-level ports.
module thresh_fifo_chk #(
    parameter int AW = 5
) (
    input logic        clk,
    input logic        rst_n,
    input logic        card_to_host,
    input logic        xfer_active,
    input logic        cfg_wr_en,
    input logic        host_wr_en,
    input logic        host_rd_en,
    input logic        host_underrun,
    input logic        card_push_en,
    input logic        card_pop_en,
    input logic [AW:0] fill_level,
    input logic        rx_dma_req,
    input logic        tx_dma_req,
    input logic        stat_almost_full,
    input logic        stat_almost_empty
);
    localparam int DEPTH = 1 << AW;

    logic push_try;
    logic pop_try;

    // Requests that the selected direction would act on.
    always_comb begin
        push_try = card_to_host ? card_push_en : host_wr_en;
        pop_try  = card_to_host ? host_rd_en : card_pop_en;
    end

    p_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= (AW+1)'(DEPTH));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == (AW+1)'(DEPTH) && push_try && !pop_try && !cfg_wr_en)
        |=> fill_level == (AW+1)'(DEPTH));

    p_underrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_underrun && !card_push_en && !cfg_wr_en) |=> fill_level == '0);

    p_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |=> fill_level == '0);

    p_rx_route_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_dma_req && stat_almost_full));

    p_tx_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_dma_req && stat_almost_empty));

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_active && fill_level == '0) |-> (!stat_almost_full && !stat_almost_empty));

    p_dir_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_dma_req || stat_almost_full, tx_dma_req || stat_almost_empty, host_underrun && !card_to_host}));

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (push_try && pop_try && !cfg_wr_en && fill_level != '0 && fill_level != (AW+1)'(DEPTH))
        |=> $stable(fill_level));

endmodule

bind thresh_fifo thresh_fifo_chk #(.AW(AW)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .card_to_host      (card_to_host),
    .xfer_active       (xfer_active),
    .cfg_wr_en         (cfg_wr_en),
    .host_wr_en        (host_wr_en),
    .host_rd_en        (host_rd_en),
    .host_underrun     (host_underrun),
    .card_push_en      (card_push_en),
    .card_pop_en       (card_pop_en),
    .fill_level        (fill_level),
    .rx_dma_req        (rx_dma_req),
    .tx_dma_req        (tx_dma_req),
    .stat_almost_full  (stat_almost_full),
    .stat_almost_empty (stat_almost_empty)
);

// File: tb/thresh_fifo_test.sv
// Bench for thresh_fifo: ordered fill and drain, wrap, overflow, underrun,
// configuration flush, and full sweeps of both watermarks.
module thresh_fifo_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        card_to_host = 1'b0;
    logic        xfer_active = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [15:0] cfg_wr_data = '0;
    logic [15:0] cfg_rd_data;
    logic        host_wr_en = 1'b0;
    logic [15:0] host_wr_data = '0;
    logic        host_rd_en = 1'b0;
    logic [15:0] host_rd_data;
    logic        host_underrun;
    logic        card_push_en = 1'b0;
    logic [15:0] card_push_data = '0;
    logic        card_pop_en = 1'b0;
    logic [15:0] card_rd_data;
    logic [5:0]  fill_level;
    logic        rx_dma_req;
    logic        tx_dma_req;
    logic        stat_almost_full;
    logic        stat_almost_empty;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    thresh_fifo uut (
        .clk (clk), .rst_n (rst_n), .card_to_host (card_to_host),
        .xfer_active (xfer_active), .cfg_wr_en (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data), .cfg_rd_data (cfg_rd_data),
        .host_wr_en (host_wr_en), .host_wr_data (host_wr_data),
        .host_rd_en (host_rd_en), .host_rd_data (host_rd_data),
        .host_underrun (host_underrun), .card_push_en (card_push_en),
        .card_push_data (card_push_data), .card_pop_en (card_pop_en),
        .card_rd_data (card_rd_data), .fill_level (fill_level),
        .rx_dma_req (rx_dma_req), .tx_dma_req (tx_dma_req),
        .stat_almost_full (stat_almost_full),
        .stat_almost_empty (stat_almost_empty)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FIFO check FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock; inputs are driven and outputs sampled 1 ns after the edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic write_cfg(input logic [15:0] w);
        cfg_wr_en = 1'b1; cfg_wr_data = w;
        tick();
        cfg_wr_en = 1'b0;
    endtask

    task automatic host_push(input logic [15:0] d);
        host_wr_en = 1'b1; host_wr_data = d;
        tick();
        host_wr_en = 1'b0;
    endtask

    task automatic card_push(input logic [15:0] d);
        card_push_en = 1'b1; card_push_data = d;
        tick();
        card_push_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FIFO check FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        int pushed;
        int popped;
        repeat (3) tick();
        rst_n = 1'b1;
        // R1 reset state
        check("R1 level", int'(fill_level), 0);
        check("R1 cfg", int'(cfg_rd_data), 16'h1F00);
        check("R1 flags", int'({rx_dma_req, tx_dma_req, stat_almost_full, stat_almost_empty}), 0);

        // R3 fill to 32 in host-to-card mode, then attempt an extra push
        xfer_active = 1'b1;
        for (int i = 0; i < 32; i++) host_push(16'hA500 + 16'(i));
        check("R3 full level", int'(fill_level), 32);
        host_push(16'hFFFF);
        check("R3 overflow level", int'(fill_level), 32);
        // R2 drain in order through the card side
        for (int i = 0; i < 32; i++) begin
            check("R2 drain order", int'(card_rd_data), int'(16'hA500 + 16'(i)));
            card_pop_en = 1'b1;
            tick();
            card_pop_en = 1'b0;
        end
        check("R2 drained", int'(fill_level), 0);

        // R11 host read in host-to-card mode: no underrun
        host_rd_en = 1'b1; #1;
        check("R11 no underrun tx", int'(host_underrun), 0);
        host_rd_en = 1'b0;

        // R4 underrun in card-to-host mode: head is entry 0 = first word
        card_to_host = 1'b1; xfer_active = 1'b0;
        host_rd_en = 1'b1; #1;
        check("R4 underrun", int'(host_underrun), 1);
        check("R4 head data", int'(host_rd_data), 16'hA500);
        tick();
        host_rd_en = 1'b0;
        check("R4 level", int'(fill_level), 0);
        // R11 host write ignored in card-to-host mode
        host_push(16'h1111);
        check("R11 host write ignored", int'(fill_level), 0);
        card_push(16'h2222);
        card_pop_en = 1'b1;
        tick();
        card_pop_en = 1'b0;
        check("R11 card pop ignored", int'(fill_level), 1);
        check("R11 head kept", int'(host_rd_data), 16'h2222);

        // R2/R12 wrap and simultaneous push+pop in host-to-card mode
        write_cfg(16'h1F00);
        card_to_host = 1'b0; xfer_active = 1'b1;
        pushed = 0; popped = 0;
        for (int i = 0; i < 20; i++) begin host_push(16'hB000 + 16'(pushed)); pushed++; end
        for (int i = 0; i < 20; i++) begin
            check("R2 pass1 order", int'(card_rd_data), int'(16'hB000 + 16'(popped)));
            card_pop_en = 1'b1; tick(); card_pop_en = 1'b0; popped++;
        end
        for (int i = 0; i < 10; i++) begin host_push(16'hB000 + 16'(pushed)); pushed++; end
        for (int i = 0; i < 30; i++) begin
            check("R2 wrap order", int'(card_rd_data), int'(16'hB000 + 16'(popped)));
            host_wr_en = 1'b1; host_wr_data = 16'hB000 + 16'(pushed);
            card_pop_en = 1'b1;
            tick();
            host_wr_en = 1'b0; card_pop_en = 1'b0;
            pushed++; popped++;
            check("R12 level held", int'(fill_level), 10);
        end
        for (int i = 0; i < 10; i++) begin
            check("R2 tail order", int'(card_rd_data), int'(16'hB000 + 16'(popped)));
            card_pop_en = 1'b1; tick(); card_pop_en = 1'b0; popped++;
        end

        // R5 field layout, reserved bits, flush
        for (int i = 0; i < 5; i++) host_push(16'h3000);
        write_cfg(16'hEAE5);
        check("R5 readback", int'(cfg_rd_data), 16'h8A85);
        check("R5 flush", int'(fill_level), 0);

        // R6 R7 R10 almost-full sweep, card-to-host, every level and count
        card_to_host = 1'b1; xfer_active = 1'b1;
        for (int en = 0; en < 2; en++) begin
            for (int lvl = 0; lvl < 32; lvl++) begin
                write_cfg({1'(en), 2'b00, 5'(lvl), 8'h00});
                for (int n = 0; n <= 32; n++) begin
                    check("R6 rx req", int'(rx_dma_req), int'(en == 1 && n > lvl));
                    check("R7 af flag", int'(stat_almost_full), int'(en == 0 && n > lvl));
                    card_push(16'(n));
                end
                // R10 pop back below the level and see the output fall
                for (int n = 32; n > 0; n--) begin
                    host_rd_en = 1'b1; tick(); host_rd_en = 1'b0;
                    check("R10 rx fall", int'(rx_dma_req | stat_almost_full), int'(n - 1 > lvl));
                end
            end
        end

        // R8 R10 almost-empty sweep, host-to-card
        card_to_host = 1'b0;
        for (int en = 0; en < 2; en++) begin
            for (int lvl = 0; lvl < 32; lvl++) begin
                write_cfg({8'h1F, 1'(en), 2'b00, 5'(lvl)});
                for (int n = 0; n <= 32; n++) begin
                    check("R8 tx req", int'(tx_dma_req), int'(en == 1 && n < lvl));
                    check("R8 ae flag", int'(stat_almost_empty), int'(en == 0 && n < lvl));
                    host_push(16'(n));
                end
                check("R10 tx full", int'(tx_dma_req | stat_almost_empty), 0);
            end
        end

        // R9 idle and empty masks the flag; one word unmasks it
        xfer_active = 1'b0;
        write_cfg(16'h1F0A);
        check("R9 idle empty ae", int'(stat_almost_empty), 0);
        check("R9 idle empty af", int'(stat_almost_full), 0);
        host_push(16'h5555);
        check("R9 idle nonempty ae", int'(stat_almost_empty), 1);

        finish_run();
    end

endmodule